// File: doc/BRIEF.md
# RTC Alarm Comparator with Repeat Masks

This block holds four alarm fields (seconds, minutes, hours and day of month) and compares them against a running BCD time of day. It raises a single-cycle interrupt pulse when the enabled fields match. The time value and a one-second strobe come from an external time counter. The block samples the comparison only on that strobe, so each matching second gives one pulse.

Bit 7 of every alarm field is a don't-care flag. Only a few nested flag patterns select a real repeat rate: monthly, daily, hourly or once a minute. Every other pattern makes the alarm fire on every second. Software loads the fields through a small write port, and each write is checked for a legal BCD value. Illegal writes are dropped without effect. The stored fields can be read back through a combinational read port.

Top module: `rtc_alarm_match`

## Requirements
- R1: `wr_sel`/`rd_sel` encode the field as 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores all 8 bits of `wr_data`, and `rd_data` shows the stored byte of `rd_sel` in the same cycle.
- R2: A seconds or minutes write is accepted only if bits 6:4 × 10 + bits 3:0 lies in 0..59. Otherwise the field keeps its old value.
- R3: An hours write is accepted only if bits 5:4 × 10 + bits 3:0 lies in 0..23. Otherwise the field keeps its old value.
- R4: A date write is accepted only if bits 5:4 × 10 + bits 3:0 is nonzero. Otherwise the field keeps its old value.
- R5: With no bit 7 set in any field, a match needs date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal to the time inputs.
- R6: With only the date flag set, a match needs hours, minutes and seconds to be equal.
- R7: With only the date and hours flags set, a match needs minutes and seconds to be equal.
- R8: With date, hours and minutes flags set and the seconds flag clear, a match needs seconds to be equal.
- R9: Every other flag pattern, including all four flags set, matches on every tick.
- R10: `alarm_irq` is high for exactly the one cycle after a `tick` cycle that matched. It is never high after a cycle with no tick.
- R11: If a write in the tick cycle is accepted and changes the stored byte, that tick gives no pulse. An accepted write that does not change the stored byte does not suppress the pulse.
- R12: A synchronous reset clears all four fields to 0x00 and holds `alarm_irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Alarm field write strobe |
| wr_sel | input | 2 | Field written (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Write byte: bit 7 is the don't-care flag, the low bits are BCD |
| rd_sel | input | 2 | Field read back |
| rd_data | output | 8 | Stored byte of the selected field |
| tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The embedded properties check the following on every cycle:
- the write acceptance rule against the stored fields, both that rejected writes keep the bank stable and that accepted writes land;
- that a pulse only follows a tick;
- that a changing write in the tick cycle blocks the pulse;
- that the all-flags pattern always fires;
- that reset forces the output low.

The actual time comparison for each repeat rate can only be shown by the bench scenarios. These drive chosen alarm settings against matching and near-miss times. The same applies to the boundary BCD values, the illegal flag patterns that fall back to per-second firing, and the difference between a changing and a non-changing write during a tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int MS_W       = 7;   // seconds / minutes BCD width
    localparam int HD_W       = 6;   // hours / date BCD width
    localparam int FLAG_BIT   = FIELD_W - 1;

    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 2'd0,
        F_MIN  = 2'd1,
        F_HOUR = 2'd2,
        F_DATE = 2'd3
    } field_sel_e;

    typedef logic [FIELD_W-1:0]     field_t;
    typedef field_t [NUM_FIELDS-1:0] field_bank_t;

    typedef struct packed {
        logic [HD_W-1:0] date;
        logic [HD_W-1:0] hour;
        logic [MS_W-1:0] min;
        logic [MS_W-1:0] sec;
    } tod_t;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MINUTE,
        RATE_SECOND
    } rate_e;

    function automatic int unsigned bcd_value(input logic [MS_W-1:0] v);
        return int'(v[6:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic write_legal(input field_sel_e sel, input field_t d);
        logic ok;
        case (sel)
            F_SEC, F_MIN: ok = (bcd_value(d[MS_W-1:0]) <= 59);
            F_HOUR:       ok = (bcd_value({1'b0, d[HD_W-1:0]}) <= 23);
            default:      ok = (bcd_value({1'b0, d[HD_W-1:0]}) != 0);
        endcase
        return ok;
    endfunction

    // flags ordered {date, hour, min, sec}
    function automatic rate_e flags_to_rate(input logic [NUM_FIELDS-1:0] f);
        rate_e r;
        case (f)
            4'b0000: r = RATE_MONTH;
            4'b1000: r = RATE_DAY;
            4'b1100: r = RATE_HOUR;
            4'b1110: r = RATE_MINUTE;
            default: r = RATE_SECOND;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alarm_field_bank.sv
module alarm_field_bank
    import rtc_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  field_t           wr_data,
    output field_bank_t      fields,
    output logic             wr_change
);

    logic accept;

    assign accept    = wr_en && write_legal(field_sel_e'(wr_sel), wr_data);
    assign wr_change = accept && (fields[wr_sel] != wr_data);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        field_t q_r;
        always_ff @(posedge clk) begin
            if (rst)
                q_r <= '0;
            else if (accept && (wr_sel == SEL_W'(i)))
                q_r <= wr_data;
        end
        assign fields[i] = q_r;
    end

    // R2 R3 R4
    // R2
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !accept) |=> (fields == $past(fields)));

    // R1
    accept_store_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (fields[$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] flags,
    input  tod_t                  alarm_val,
    input  tod_t                  now,
    output rate_e                 rate,
    output logic                  match
);

    logic eq_sec, eq_min, eq_hour, eq_date;

    assign eq_sec  = (alarm_val.sec  == now.sec);
    assign eq_min  = (alarm_val.min  == now.min);
    assign eq_hour = (alarm_val.hour == now.hour);
    assign eq_date = (alarm_val.date == now.date);

    assign rate = flags_to_rate(flags);

    always_comb begin
        case (rate)
            RATE_MONTH:  match = eq_date && eq_hour && eq_min && eq_sec;
            RATE_DAY:    match = eq_hour && eq_min && eq_sec;
            RATE_HOUR:   match = eq_min && eq_sec;
            RATE_MINUTE: match = eq_sec;
            default:     match = 1'b1;
        endcase
    end

endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    input  logic wr_change,
    output logic irq
);

    logic irq_r;

    always_ff @(posedge clk) begin
        if (rst)
            irq_r <= 1'b0;
        else
            irq_r <= tick && match && !wr_change;
    end

    assign irq = irq_r;

    // R10
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick));

    // R10
    no_tick_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !irq);

    // R11
    change_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_change) |=> !irq);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [5:0] now_hour,
    input  logic [5:0] now_date,
    output logic       alarm_irq
);

    field_bank_t           fields;
    logic                  wr_change;
    logic [NUM_FIELDS-1:0] flags;
    tod_t                  alarm_val;
    tod_t                  now;
    rate_e                 rate;
    logic                  match;

    alarm_field_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .fields    (fields),
        .wr_change (wr_change)
    );

    assign flags = {fields[F_DATE][FLAG_BIT], fields[F_HOUR][FLAG_BIT],
                    fields[F_MIN][FLAG_BIT],  fields[F_SEC][FLAG_BIT]};

    assign alarm_val.sec  = fields[F_SEC][MS_W-1:0];
    assign alarm_val.min  = fields[F_MIN][MS_W-1:0];
    assign alarm_val.hour = fields[F_HOUR][HD_W-1:0];
    assign alarm_val.date = fields[F_DATE][HD_W-1:0];

    assign now = '{date: now_date, hour: now_hour, min: now_min, sec: now_sec};

    alarm_comparator u_cmp (
        .flags     (flags),
        .alarm_val (alarm_val),
        .now       (now),
        .rate      (rate),
        .match     (match)
    );

    alarm_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .match     (match),
        .wr_change (wr_change),
        .irq       (alarm_irq)
    );

    assign rd_data = fields[rd_sel];

    // R9
    all_flags_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (&flags) && !wr_change) |=> alarm_irq);

    // R9
    fallback_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (rate == RATE_SECOND) && !wr_change) |=> alarm_irq);

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (fields == '0));

endmodule

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] a_sec;
        logic [7:0] a_min;
        logic [7:0] a_hour;
        logic [7:0] a_date;
        logic [6:0] t_sec;
        logic [6:0] t_min;
        logic [5:0] t_hour;
        logic [5:0] t_date;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h30, 8'h15, 8'h12, 8'h21, 7'h30, 7'h15, 6'h12, 6'h21, 1'b1, 4'd5},  // R5 full match
        '{8'h30, 8'h15, 8'h12, 8'h21, 7'h30, 7'h15, 6'h12, 6'h22, 1'b0, 4'd5},  // R5 date miss
        '{8'h30, 8'h15, 8'h12, 8'h81, 7'h30, 7'h15, 6'h12, 6'h05, 1'b1, 4'd6},  // R6 daily
        '{8'h30, 8'h15, 8'h12, 8'h81, 7'h30, 7'h15, 6'h11, 6'h05, 1'b0, 4'd6},  // R6 hour miss
        '{8'h30, 8'h15, 8'h92, 8'h81, 7'h30, 7'h15, 6'h07, 6'h09, 1'b1, 4'd7},  // R7 hourly
        '{8'h30, 8'h15, 8'h92, 8'h81, 7'h30, 7'h16, 6'h07, 6'h09, 1'b0, 4'd7},  // R7 minute miss
        '{8'h30, 8'h95, 8'h92, 8'h81, 7'h30, 7'h44, 6'h03, 6'h02, 1'b1, 4'd8},  // R8 per minute
        '{8'h30, 8'h95, 8'h92, 8'h81, 7'h31, 7'h44, 6'h03, 6'h02, 1'b0, 4'd8},  // R8 second miss
        '{8'hB0, 8'h95, 8'h92, 8'h81, 7'h01, 7'h02, 6'h03, 6'h04, 1'b1, 4'd9},  // R9 all flags
        '{8'hB0, 8'h15, 8'h12, 8'h21, 7'h00, 7'h00, 6'h00, 6'h01, 1'b1, 4'd9},  // R9 sec flag only
        '{8'h30, 8'h15, 8'h92, 8'h21, 7'h11, 7'h22, 6'h13, 6'h14, 1'b1, 4'd9},  // R9 hour flag only
        '{8'h59, 8'h59, 8'h23, 8'h31, 7'h59, 7'h59, 6'h23, 6'h31, 1'b1, 4'd5}   // R5 top values
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_date = '0;
    logic       alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_field(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                            input logic [5:0] h, input logic [5:0] d);
        now_sec = s; now_min = m; now_hour = h; now_date = d;
    endtask

    // one tick; irq checked in the cycle after the tick edge, then its drop
    task automatic tick_check(input string tag, input logic exp);
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1;
        check(tag, {7'b0, alarm_irq}, {7'b0, exp});
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R10 pulse drop", {7'b0, alarm_irq}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        check("R12 irq after reset", {7'b0, alarm_irq}, 8'h00);
        for (int i = 0; i < 4; i++) read_check("R12 field reset", 2'(i), 8'h00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
            write_field(2'd0, VECS[v].a_sec);
            write_field(2'd1, VECS[v].a_min);
            write_field(2'd2, VECS[v].a_hour);
            write_field(2'd3, VECS[v].a_date);
            set_time(VECS[v].t_sec, VECS[v].t_min, VECS[v].t_hour, VECS[v].t_date);
            tick_check(tag, VECS[v].exp);
        end

        // R1 R2 R3 R4 write acceptance and readback
        write_field(2'd0, 8'h59);  read_check("R2 sec 59 accepted", 2'd0, 8'h59);
        write_field(2'd0, 8'h60);  read_check("R2 sec 60 rejected", 2'd0, 8'h59);
        write_field(2'd1, 8'h00);  read_check("R2 min 00 accepted", 2'd1, 8'h00);
        write_field(2'd1, 8'h7F);  read_check("R2 min 85 rejected", 2'd1, 8'h00);
        write_field(2'd2, 8'h23);  read_check("R3 hour 23 accepted", 2'd2, 8'h23);
        write_field(2'd2, 8'h24);  read_check("R3 hour 24 rejected", 2'd2, 8'h23);
        write_field(2'd2, 8'hE4);  read_check("R3 hour 24 flagged rejected", 2'd2, 8'h23);
        write_field(2'd3, 8'hC1);  read_check("R1 date all bits kept", 2'd3, 8'hC1);
        write_field(2'd3, 8'h80);  read_check("R4 date zero rejected", 2'd3, 8'hC1);
        write_field(2'd3, 8'h3F);  read_check("R4 date nonzero accepted", 2'd3, 8'h3F);

        // R10 matching time but no tick
        write_field(2'd0, 8'h30);
        write_field(2'd1, 8'h15);
        write_field(2'd2, 8'h12);
        write_field(2'd3, 8'h21);
        set_time(7'h30, 7'h15, 6'h12, 6'h21);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            check("R10 no tick no irq", {7'b0, alarm_irq}, 8'h00);
        end

        // R11 changing write in the tick cycle suppresses the pulse
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h31;
        tick = 1'b1;
        @(posedge clk); #1;
        check("R11 changing write suppresses", {7'b0, alarm_irq}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        read_check("R11 write landed", 2'd0, 8'h31);
        set_time(7'h31, 7'h15, 6'h12, 6'h21);
        tick_check("R11 new value matches", 1'b1);

        // R11 same-value write does not suppress
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h31;
        tick = 1'b1;
        @(posedge clk); #1;
        check("R11 same value write fires", {7'b0, alarm_irq}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;

        // R12 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 irq low after reset", {7'b0, alarm_irq}, 8'h00);
        read_check("R12 sec cleared", 2'd0, 8'h00);
        read_check("R12 date cleared", 2'd3, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule